// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

A single 16-bit timer channel built around a counter that advances once per tick of a selectable prescaler. Four general registers, named A, B, C and D, each act on their own as either a compare register, which changes a pin when the counter reaches it, or a capture register, which latches the counter when an edge arrives on its input pin. Any one register's event may reset the counter to zero, which sets the period of a repeating waveform.

Registers C and D can be paired with A and B as buffers. In a compare pairing, the buffer value is loaded into the working register on each match, so software can stage the next compare value without a glitch. In a capture pairing, the previous capture moves into the buffer when the new one lands, keeping the last two captured values. Every event sets a sticky status flag that software clears by writing zero to that bit. Configuration and readback go through a simple 16-bit register port.

Counting is governed by a two-state machine. ST_HALT is the reset state and the counter holds. The transition GO (run bit written to 1) enters ST_COUNT, where the counter advances on ticks. The transition STOP (run bit written to 0) returns to ST_HALT. Each transition takes effect one clock after the write.

Top module: `tmr_chan`

## Requirements
- R1: After reset, every register reads 0, all compare outputs are low, and the channel is in ST_HALT.
- R2: Register map (addr): 0 control, 1 mode, 2 counter, 3 flags, 4–7 registers A–D. Control fields are clock select [2:0], clear select [5:3] (0 none, 1–4 = A–D), pair A/C [6], pair B/D [7] and run [8]. Control bits [15:9] read as 0. The mode word gives each register r a nibble [4r+3:4r].
- R3: In ST_COUNT the counter adds one on each prescaler tick. A clock select of s gives one tick every 2^s system clocks. In ST_HALT the counter holds.
- R4: A compare match occurs on a tick when the counter equals a compare register (mode nibble bit 0 = 0). Its nibble bits [2:1] then set the output: 01 drives it low, 10 drives it high, 11 toggles it, and 00 leaves it as it was. Outputs change only on a match.
- R5: When the register named by clear select has an event, the counter loads 0 instead of advancing. A compare period is therefore register value + 1 ticks.
- R6: A capture register (nibble bit 0 = 1) loads the counter on the edges chosen by bits [2:1] of its nibble: 01 rising, 10 falling, 11 both. The pin passes through a two-flop synchronizer, and the edge is detected on the system clock.
- R7: In capture pairing, one capture event on A (B) loads the counter into A (B) and moves the old A (B) into C (D) in the same cycle.
- R8: In compare pairing, a match on A (B) copies C (D) into A (B). While paired, C (D) produce no events of their own.
- R9: Each event sets its flag bit (bit r for register r). Writing 0 to a flag bit clears it. Writing 1 to a flag bit has no effect.
- R10: Clearing on a capture event works whether or not the counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| cap_in | input | 4 | Capture input pins, one per register |
| cmp_out | output | 4 | Compare output pins, one per register |

## Verification
The bench builds the channel with its default parameters: 16-bit counter, prescaler step of one doubling per select code, and two synchronizer stages. With these defaults, a divide-by-four tick yields a 16-cycle compare period, and all eight divisors stay within a short run. Capture checks run with the counter halted, so each captured value is exactly the count the bench wrote. Edge selection, capture pairing and clear-on-capture can therefore be judged without any dependence on timing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NREG = 4;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

    localparam logic [2:0] AD_CTRL = 3'd0;
    localparam logic [2:0] AD_MODE = 3'd1;
    localparam logic [2:0] AD_CNT  = 3'd2;
    localparam logic [2:0] AD_FLAG = 3'd3;

    localparam logic [1:0] ACT_NONE   = 2'b00;
    localparam logic [1:0] ACT_LOW    = 2'b01;
    localparam logic [1:0] ACT_HIGH   = 2'b10;
    localparam logic [1:0] ACT_TOGGLE = 2'b11;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W    = 3,
    parameter int PRE_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = ((1 << SEL_W) - 1) * PRE_STEP;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask = DIV_W'((64'd1 << (int'(sel) * PRE_STEP)) - 64'd1);
        tick = ((div_q & mask) == mask);
    end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW       = 16,
    parameter int PRE_STEP = 1,
    parameter int SYNC     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [CW-1:0]       wdata,
    output logic [CW-1:0]       rdata,
    input  logic [NREG-1:0]     cap_in,
    output logic [NREG-1:0]     cmp_out
);
    localparam int MODE_W = 4 * NREG;

    logic [2:0]        clk_sel;
    logic [2:0]        clr_sel;
    logic [1:0]        buf_en;
    logic              run_bit;
    logic [MODE_W-1:0] mode_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     gr_q [NREG];
    logic [NREG-1:0]   flag_q;
    logic [NREG-1:0]   out_q;
    logic [NREG-1:0]   rise, fall;
    logic [NREG-1:0]   match_ev, cap_ev;
    logic              clr_hit;
    logic              tick;
    logic              cnt_en;
    run_state_t        state_q, state_d;

    tmr_prescale #(.SEL_W(3), .PRE_STEP(PRE_STEP)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_edge
        tmr_edge #(.STAGES(SYNC)) u_edge (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[g]),
            .rise(rise[g]), .fall(fall[g])
        );
    end

    // run state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run_bit)  state_d = ST_COUNT;   // GO
            ST_COUNT: if (!run_bit) state_d = ST_HALT;    // STOP
        endcase
    end

    // state outputs
    always_comb cnt_en = (state_q == ST_COUNT);

    // event decode
    always_comb begin
        match_ev = '0;
        cap_ev   = '0;
        clr_hit  = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            if (!((r >= 2) && buf_en[r % 2])) begin
                match_ev[r] = !mode_q[4*r] && cnt_en && tick && (cnt_q == gr_q[r]);
                cap_ev[r]   = mode_q[4*r] &&
                              ((mode_q[4*r+1] && rise[r]) || (mode_q[4*r+2] && fall[r]));
            end
            if ((clr_sel == 3'(r + 1)) && (match_ev[r] || cap_ev[r])) clr_hit = 1'b1;
        end
    end

    // configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel <= '0;
            clr_sel <= '0;
            buf_en  <= '0;
            run_bit <= 1'b0;
            mode_q  <= '0;
        end else if (wr_en) begin
            if (addr == AD_CTRL) begin
                clk_sel <= wdata[2:0];
                clr_sel <= wdata[5:3];
                buf_en  <= wdata[7:6];
                run_bit <= wdata[8];
            end
            if (addr == AD_MODE) mode_q <= wdata[MODE_W-1:0];
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (wr_en && addr == AD_CNT)   cnt_q <= wdata;
        else if (clr_hit)                   cnt_q <= '0;
        else if (cnt_en && tick)            cnt_q <= cnt_q + 1'b1;
    end

    // general registers with buffer pairing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) gr_q[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++)
                if (wr_en && addr == 3'(4 + r)) gr_q[r] <= wdata;
            for (int r = 0; r < 2; r++) begin
                if (cap_ev[r]) begin
                    gr_q[r] <= cnt_q;
                    if (buf_en[r]) gr_q[r+2] <= gr_q[r];
                end else if (match_ev[r] && buf_en[r]) begin
                    gr_q[r] <= gr_q[r+2];
                end
            end
            for (int r = 2; r < NREG; r++)
                if (cap_ev[r]) gr_q[r] <= cnt_q;
        end
    end

    // compare outputs
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else begin
            for (int r = 0; r < NREG; r++) begin
                if (match_ev[r]) begin
                    unique case (mode_q[4*r+1 +: 2])
                        ACT_NONE:   out_q[r] <= out_q[r];
                        ACT_LOW:    out_q[r] <= 1'b0;
                        ACT_HIGH:   out_q[r] <= 1'b1;
                        ACT_TOGGLE: out_q[r] <= ~out_q[r];
                    endcase
                end
            end
        end
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else flag_q <= ((wr_en && addr == AD_FLAG) ? (flag_q & wdata[NREG-1:0]) : flag_q)
                       | match_ev | cap_ev;
    end

    assign cmp_out = out_q;

    always_comb begin
        rdata = '0;
        if (addr[2]) rdata = gr_q[addr[1:0]];
        else begin
            unique case (addr[1:0])
                2'd0: rdata = CW'({run_bit, buf_en, clr_sel, clk_sel});
                2'd1: rdata = CW'(mode_q);
                2'd2: rdata = cnt_q;
                2'd3: rdata = CW'(flag_q);
            endcase
        end
    end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      addr,
    input logic [CW-1:0]   cnt_q,
    input logic [NREG-1:0] flag_q,
    input logic [NREG-1:0] cmp_out,
    input logic [NREG-1:0] match_ev,
    input logic            clr_hit,
    input logic            cnt_en,
    input logic            tick
);
    logic wr_cnt, wr_flag;
    assign wr_cnt  = wr_en && (addr == AD_CNT);
    assign wr_flag = wr_en && (addr == AD_FLAG);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && tick && !wr_cnt && !clr_hit) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_cnt && !clr_hit) |=> $stable(cnt_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !wr_cnt) |=> (cnt_q == '0)); // R5
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev == '0) |=> $stable(cmp_out)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R9
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .cnt_q(cnt_q),
    .flag_q(flag_q), .cmp_out(cmp_out), .match_ev(match_ev),
    .clr_hit(clr_hit), .cnt_en(cnt_en), .tick(tick)
);

// File: tb/tb_tmr_chan.sv
`timescale 1ns/1ps
module tb_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  cmp_out;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    // {addr, write data, expected read}
    localparam logic [34:0] VEC [8] = '{
        {3'd4, 16'hFFFF, 16'hFFFF},
        {3'd5, 16'h1357, 16'h1357},
        {3'd6, 16'h8001, 16'h8001},
        {3'd7, 16'h00FF, 16'h00FF},
        {3'd2, 16'hBEEF, 16'hBEEF},
        {3'd0, 16'hFE45, 16'h0045},
        {3'd1, 16'h1248, 16'h1248},
        {3'd3, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(input int idx, output int per);
        logic v;
        int n;
        v = cmp_out[idx]; n = 0;
        while (cmp_out[idx] == v && n < 1000) begin @(posedge clk); #1; n++; end
        v = cmp_out[idx]; n = 0;
        while (cmp_out[idx] == v && n < 1000) begin @(posedge clk); #1; n++; end
        per = n;
    endtask

    initial begin
        logic [15:0] d, d2;
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset read", d, 16'h0);
        end
        chk("R1 outputs low", {12'h0, cmp_out}, 16'h0);

        // R2 / R9 register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][34:32], VEC[i][31:16]);
            rd(VEC[i][34:32], d);
            chk("R2 readback", d, VEC[i][15:0]);
        end
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);

        // R4 R5 toggle with clear on A, period A+1
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'd4);
        wr(3'd1, 16'h0006);
        wr(3'd0, 16'h0108);
        period(0, per);
        chk("R5 period sel0", 16'(per), 16'd5);
        rd(3'd3, d);
        chk("R9 flag A set", d & 16'h1, 16'h1);

        // R3 prescaler divide by 4
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'h010A);
        period(0, per);
        chk("R3 period div4", 16'(per), 16'd16);

        // R3 halt holds count
        wr(3'd0, 16'h0000);
        rd(3'd2, d);
        waitc(10);
        rd(3'd2, d2);
        chk("R3 halt hold", d2, d);

        // R4 drive high then low
        wr(3'd1, 16'h0040);
        wr(3'd2, 16'h0000);
        wr(3'd5, 16'd2);
        wr(3'd0, 16'h0100);
        waitc(10);
        chk("R4 drive high", {15'h0, cmp_out[1]}, 16'h1);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0020);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0100);
        waitc(10);
        chk("R4 drive low", {15'h0, cmp_out[1]}, 16'h0);
        wr(3'd0, 16'h0000);

        // R9 write 0 clears, write 1 keeps
        wr(3'd3, 16'hFFFE);
        rd(3'd3, d);
        chk("R9 flag clear", d, 16'h0002);

        // R6 capture edges, counter halted
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'h1234);
        cap_in[0] = 1'b1; waitc(5);
        rd(3'd4, d);
        chk("R6 rising capture", d, 16'h1234);
        wr(3'd2, 16'h2222);
        cap_in[0] = 1'b0; waitc(5);
        rd(3'd4, d);
        chk("R6 falling ignored", d, 16'h1234);
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h3333);
        cap_in[0] = 1'b1; waitc(5);
        rd(3'd4, d);
        chk("R6 both rise", d, 16'h3333);
        wr(3'd2, 16'h4444);
        cap_in[0] = 1'b0; waitc(5);
        rd(3'd4, d);
        chk("R6 both fall", d, 16'h4444);

        // R7 capture pairing
        wr(3'd0, 16'h0040);
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'h0010);
        cap_in[0] = 1'b1; waitc(5);
        rd(3'd4, d);
        chk("R7 A first", d, 16'h0010);
        rd(3'd6, d);
        chk("R7 C old A", d, 16'h4444);
        cap_in[0] = 1'b0; waitc(5);
        wr(3'd2, 16'h0020);
        cap_in[0] = 1'b1; waitc(5);
        rd(3'd4, d);
        chk("R7 A second", d, 16'h0020);
        rd(3'd6, d);
        chk("R7 C first", d, 16'h0010);

        // R10 clear on capture while halted
        wr(3'd0, 16'h0008);
        wr(3'd1, 16'h0007);
        wr(3'd2, 16'h0050);
        cap_in[0] = 1'b0; waitc(5);
        rd(3'd2, d);
        chk("R10 count cleared", d, 16'h0000);
        rd(3'd4, d);
        chk("R10 A captured", d, 16'h0050);

        // R8 compare pairing reload
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'd3);
        wr(3'd6, 16'd7);
        wr(3'd0, 16'h0148);
        waitc(20);
        rd(3'd4, d);
        chk("R8 A reloaded", d, 16'd7);
        rd(3'd6, d);
        chk("R8 C kept", d, 16'd7);
        wr(3'd0, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule